// File: doc/BRIEF.md
# Relative branch program counter unit

This block owns the program counter of a small processor whose instructions are 16-bit words in a byte-addressed program space. Each instruction cycle is split into four phases, Q1 to Q4, advanced by a phase enable input. In sequential flow the counter moves forward by one word (2 bytes) at the end of every cycle that fetched an instruction.

The block recognises one instruction, an unconditional relative branch, which carries a signed word offset. Because the counter has already moved past the branch when it is applied, the branch lands at the counter plus 2 plus twice the offset. The new counter value appears only at the Q4 step of the branch cycle. The following instruction cycle then acts as a forced no-op: the flush output tells the pipeline to drop the word that was prefetched. The busy output covers both cycles of the branch.

Top module: `rel_branch_pc`

## Requirements
- R1: A synchronous reset sets pc to 0 and phase to 0 (Q1), and clears flush and busy.
- R2: phase steps 0,1,2,3,0 (Q1..Q4) on each clock with ph_en high; with ph_en low, pc, phase, flush and busy all hold.
- R3: A cycle whose Q1 step sees fetch_valid high and no branch adds 2 to pc at its Q4 step, modulo 2^21.
- R4: A cycle whose Q1 step sees fetch_valid low leaves pc unchanged.
- R5: A word with bits [15:11] = 11010 seen at Q1 with fetch_valid high and flush low is a branch. Bits [10:0] form a two's-complement offset n from -1024 to +1023. pc keeps its value through Q1 to Q3 and becomes pc + 2 + 2n at the Q4 step.
- R6: flush rises at the Q4 step of a branch cycle and stays high for the whole next instruction cycle, falling at that cycle's Q4 step.
- R7: busy rises at the Q1 step of a branch cycle and stays high until the Q4 step of the flush cycle.
- R8: During a flush cycle the instruction word is ignored, even if it is a branch: pc only advances by 2 if fetch_valid was high at Q1, and no new flush follows.
- R9: pc wraps modulo 2^21 in both directions, and pc bit 0 is always 0.
- R10: Words whose top five bits differ from 11010 (for example 11011 or 11001) are handled as sequential instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ph_en | input | 1 | Phase enable: each high clock completes one phase |
| fetch_valid | input | 1 | Instruction word is valid, sampled at the Q1 step |
| instr | input | 16 | Fetched instruction word, sampled at the Q1 step |
| pc | output | 21 | Program counter (byte address, even) |
| phase | output | 2 | Phase the next enabled clock completes (0 = Q1 ... 3 = Q4) |
| flush | output | 1 | Current cycle is the no-op slot after a taken branch |
| busy | output | 1 | A branch is in its decode or flush cycle |

## Verification
Each result is due at a fixed phase step. The decision to branch and busy are visible after the Q1 step. The new pc and the rise of flush are visible only after the Q4 step, while pc must read its old value after Q1, Q2 and Q3. flush and busy fall one full instruction cycle later, after the next Q4 step. The bench drives each instruction word before its Q1 step and samples every output half a clock after each enabled edge. It compares against values that a small per-cycle model of the counter predicts from the opcode, offset, fetch_valid and the previous flush. It does this for every phase, so a result that arrives one phase early or late is caught.

// File: rtl/rbpc_pkg.sv
package rbpc_pkg;
  localparam int unsigned PC_W     = 21;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned OPC_W    = 5;
  localparam logic [OPC_W-1:0] OPC_REL_BR = 5'b11010;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;
endpackage

// File: rtl/rbpc_phase.sv
module rbpc_phase
  import rbpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ph_en,
  output phase_e phase_q,
  output logic   step_q1,
  output logic   step_q4
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_Q1;
    end else if (ph_en) begin
      phase_q <= phase_e'(phase_q + 2'd1);
    end
  end

  assign step_q1 = ph_en && (phase_q == PH_Q1);
  assign step_q4 = ph_en && (phase_q == PH_Q4);
endmodule

// File: rtl/rbpc_decode.sv
module rbpc_decode
  import rbpc_pkg::*;
#(
  parameter int unsigned IW  = WORD_W,
  parameter int unsigned OPW = OPC_W,
  localparam int unsigned OW = IW - OPW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_q1,
  input  logic          step_q4,
  input  logic          fetch_valid,
  input  logic [IW-1:0] instr,
  output logic          br_pend,
  output logic          act_q,
  output logic [OW-1:0] off_q,
  output logic          flush
);
  function automatic logic is_branch_word(input logic [IW-1:0] w);
    return w[IW-1 -: OPW] == OPC_REL_BR;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      br_pend <= 1'b0;
      act_q   <= 1'b0;
      off_q   <= '0;
      flush   <= 1'b0;
    end else begin
      if (step_q1) begin
        act_q   <= fetch_valid;
        br_pend <= fetch_valid && !flush && is_branch_word(instr);
        off_q   <= instr[OW-1:0];
      end
      if (step_q4) begin
        flush   <= br_pend;
        br_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rbpc_pc.sv
module rbpc_pc #(
  parameter int unsigned AW = 21,
  parameter int unsigned OW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_q4,
  input  logic          br_pend,
  input  logic          act_q,
  input  logic [OW-1:0] off_q,
  output logic [AW-1:0] pc_q
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(2);

  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] cur);
    return cur + WORD_BYTES;
  endfunction

  function automatic logic [AW-1:0] branch_target(input logic [AW-1:0] cur,
                                                  input logic [OW-1:0] off);
    logic [AW-1:0] sext;
    sext = {{(AW-OW){off[OW-1]}}, off};
    return cur + WORD_BYTES + (sext << 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (step_q4) begin
      if (br_pend) begin
        pc_q <= branch_target(pc_q, off_q);
      end else if (act_q) begin
        pc_q <= seq_next(pc_q);
      end
    end
  end
endmodule

// File: rtl/rel_branch_pc.sv
module rel_branch_pc
  import rbpc_pkg::*;
#(
  parameter int unsigned AW = PC_W,
  parameter int unsigned IW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_en,
  input  logic          fetch_valid,
  input  logic [IW-1:0] instr,
  output logic [AW-1:0] pc,
  output logic [1:0]    phase,
  output logic          flush,
  output logic          busy
);
  localparam int unsigned OW = IW - OPC_W;

  phase_e        phase_q;
  logic          step_q1;
  logic          step_q4;
  logic          br_pend;
  logic          act_q;
  logic [OW-1:0] off_q;
  logic          br_take;
  logic          seq_step;

  rbpc_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .ph_en   (ph_en),
    .phase_q (phase_q),
    .step_q1 (step_q1),
    .step_q4 (step_q4)
  );

  rbpc_decode #(.IW(IW), .OPW(OPC_W)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .step_q1     (step_q1),
    .step_q4     (step_q4),
    .fetch_valid (fetch_valid),
    .instr       (instr),
    .br_pend     (br_pend),
    .act_q       (act_q),
    .off_q       (off_q),
    .flush       (flush)
  );

  rbpc_pc #(.AW(AW), .OW(OW)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .step_q4 (step_q4),
    .br_pend (br_pend),
    .act_q   (act_q),
    .off_q   (off_q),
    .pc_q    (pc)
  );

  // named events for the checker
  assign br_take  = step_q4 && br_pend;
  assign seq_step = step_q4 && act_q && !br_pend;

  assign phase = phase_q;
  assign busy  = br_pend || flush;
endmodule

// File: rtl/rbpc_chk.sv
module rbpc_chk #(
  parameter int unsigned AW = 21
) (
  input logic          clk,
  input logic          rst,
  input logic          ph_en,
  input logic [AW-1:0] pc,
  input logic [1:0]    phase,
  input logic          flush,
  input logic          busy,
  input logic          step_q1,
  input logic          step_q4,
  input logic          br_take,
  input logic          seq_step,
  input logic          br_pend
);
  p_pc_even_r9: assert property (@(posedge clk) disable iff (rst)
    pc[0] == 1'b0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ph_en |=> $stable(pc) && $stable(phase) && $stable(flush) && $stable(busy));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    ph_en |=> phase == 2'($past(phase) + 2'd1));

  p_pc_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !step_q4 |=> $stable(pc));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    seq_step |=> pc == AW'($past(pc) + AW'(2)));

  p_flush_after_take_r6: assert property (@(posedge clk) disable iff (rst)
    br_take |=> flush);

  p_busy_covers_flush_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> busy);

  p_flush_gates_r8: assert property (@(posedge clk) disable iff (rst)
    (step_q1 && flush) |=> !br_pend);
endmodule

bind rel_branch_pc rbpc_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ph_en    (ph_en),
  .pc       (pc),
  .phase    (phase),
  .flush    (flush),
  .busy     (busy),
  .step_q1  (step_q1),
  .step_q4  (step_q4),
  .br_take  (br_take),
  .seq_step (seq_step),
  .br_pend  (br_pend)
);

// File: tb/sim_rel_branch_pc.sv
module sim_rel_branch_pc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ph_en = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [20:0] pc;
  logic [1:0]  phase;
  logic        flush;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [20:0] m_pc = '0;
  bit          m_fl = 1'b0;

  always #10 clk = ~clk;

  rel_branch_pc u0 (
    .clk(clk), .rst(rst), .ph_en(ph_en), .fetch_valid(fetch_valid),
    .instr(instr), .pc(pc), .phase(phase), .flush(flush), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // one instruction cycle; expectations come from a per-cycle model
  task automatic run_cycle(input logic [15:0] w, input logic v, input string req);
    logic [20:0] old;
    logic [20:0] nx;
    bit take;
    int off;
    old  = m_pc;
    take = v && !m_fl && (w[15:11] == 5'b11010);
    off  = int'($signed(w[10:0]));
    if (take)  nx = 21'(int'(old) + 2 + 2 * off);
    else if (v) nx = 21'(old + 21'd2);
    else       nx = old;
    fetch_valid = v;
    instr = w;
    for (int k = 1; k <= 4; k++) begin
      tick();
      fetch_valid = 1'b0;
      if (k < 4) begin
        check(phase == 2'(k), req, "phase mid", phase, k);
        check(pc == old, req, "pc held before Q4", pc, old);
        check(flush == m_fl, req, "flush mid", flush, m_fl);
        check(busy == (take || m_fl), req, "busy mid", busy, take || m_fl);
      end else begin
        check(phase == 2'd0, req, "phase wrap", phase, 0);
        check(pc == nx, req, "pc after Q4", pc, nx);
        check(flush == take, req, "flush after Q4", flush, take);
        check(busy == take, req, "busy after Q4", busy, take);
      end
    end
    m_pc = nx;
    m_fl = take;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    ph_en = 1'b1;
    repeat (3) tick();
    check(pc == 0, "R1", "pc in reset", pc, 0);
    check(phase == 0, "R1", "phase in reset", phase, 0);
    check(flush == 0, "R1", "flush in reset", flush, 0);
    check(busy == 0, "R1", "busy in reset", busy, 0);
    rst = 1'b0;
    m_pc = '0;
    m_fl = 1'b0;
  endtask

  task automatic t_sequential();
    run_cycle(16'h0000, 1'b1, "R3");
    run_cycle(16'h1234, 1'b1, "R3");
    run_cycle(16'hFFFF, 1'b1, "R3");
  endtask

  task automatic t_stall();
    run_cycle(16'h0000, 1'b0, "R4");
    run_cycle(16'hD005, 1'b0, "R4");
  endtask

  task automatic t_hold();
    logic [20:0] p0;
    logic [1:0]  ph0;
    fetch_valid = 1'b1;
    instr = 16'hD005;
    tick();
    fetch_valid = 1'b0;
    tick();
    p0 = pc;
    ph0 = phase;
    check(busy == 1'b1, "R2", "busy before hold", busy, 1);
    ph_en = 1'b0;
    repeat (4) tick();
    check(phase == ph0, "R2", "phase held", phase, ph0);
    check(pc == p0, "R2", "pc held", pc, p0);
    check(busy == 1'b1, "R2", "busy held", busy, 1);
    ph_en = 1'b1;
    tick();
    tick();
    check(pc == 21'(p0 + 21'd12), "R2", "branch after hold", pc, p0 + 12);
    m_pc = pc;
    m_fl = 1'b1;
    run_cycle(16'h0000, 1'b1, "R6");
  endtask

  task automatic t_forward();
    run_cycle(16'hD005, 1'b1, "R5");
    run_cycle(16'hD00F, 1'b1, "R8");
  endtask

  task automatic t_extremes();
    run_cycle(16'hD3FF, 1'b1, "R5");
    run_cycle(16'h0000, 1'b0, "R7");
    run_cycle(16'hD400, 1'b1, "R5");
    run_cycle(16'h0000, 1'b1, "R6");
  endtask

  task automatic t_wrap();
    run_cycle(16'hD400, 1'b1, "R9");
    check(pc[0] == 1'b0, "R9", "pc even after wrap down", pc[0], 0);
    check(pc > 21'd1048576, "R9", "pc wrapped to top", pc, m_pc);
    run_cycle(16'hD005, 1'b1, "R8");
    run_cycle(16'hD3FF, 1'b1, "R9");
    run_cycle(16'h0000, 1'b1, "R9");
    check(pc[0] == 1'b0, "R9", "pc even after wrap up", pc[0], 0);
  endtask

  task automatic t_near_miss();
    run_cycle(16'hD800, 1'b1, "R10");
    run_cycle(16'hC805, 1'b1, "R10");
    run_cycle(16'hD7FF, 1'b1, "R5");
    run_cycle(16'hD000, 1'b1, "R8");
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_stall();
    t_hold();
    t_forward();
    t_extremes();
    t_wrap();
    t_near_miss();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule